// File: doc/BRIEF.md
# Multi-Mode Double-Precision Min/Max Unit

This block selects the minimum or the maximum of two 64-bit double-precision operands under one of sixteen semantics chosen by a 4-bit mode code. It covers four NaN families: a 2008-style number-preferring family, a 2019 NaN-propagating family, a 2019 number-preferring family and a plain compare-select. Each family also has a magnitude-ordered variant. All ordering is done on the raw sign-magnitude bit patterns with unsigned comparators, so the unit needs no floating-point adder or subtractor.

Operands, the mode and a trap-enable bit are captured on an input strobe. One clock later the unit presents the selected result with a valid flag, a flag that reports a signaling NaN among the inputs, and a write-enable for the destination. The write-enable is withheld only when the trap is enabled and a signaling NaN was seen. Control is a two-state machine. `ST_EMPTY` moves to `ST_LOADED` when `in_valid` is high at a clock edge. `ST_LOADED` stays loaded on a further strobe and returns to `ST_EMPTY` when no strobe arrives. Outputs are meaningful only in `ST_LOADED`.

Top module: `fmm_unit`

## Requirements
- R1: After reset, `out_valid`, `wr_en`, `snan_flag` and `result` are all zero until the first strobe has been captured.
- R2: A strobe on `in_valid` at a rising edge makes `out_valid` high during the next cycle, with the result for those operands. A cycle with no strobe gives `out_valid` low in the following cycle. Back-to-back strobes give back-to-back results.
- R3: For non-NaN operands in non-magnitude modes of families 00, 01 and 10, the minimum mode (`mode[3]`=0) returns A when A orders strictly below B, otherwise B. The maximum mode (`mode[3]`=1) returns A when A orders strictly above B, otherwise B. In this ordering -0.0 is below +0.0 and infinities are ordinary values.
- R4: In family 11 (`mode[1:0]`=11), a zero of either sign is ordered as +0.0. Two zeros therefore compare equal and the result is B.
- R5: With `mode[2]`=1 and no NaN present, the operand of smaller magnitude (min) or larger magnitude (max) is returned when the magnitudes differ. When they are equal, the result is that of the same family without magnitude ordering.
- R6: An operand is NaN when its low 63 bits exceed 0x7FF0_0000_0000_0000. It is signaling when bit 51 is also 0, and quieting sets bit 51. In family 00, when a NaN is present, the result is chosen in this order: quieted A if A is signaling, else quieted B if B is signaling, else quieted A if both are NaN, else the non-NaN operand.
- R7: In family 01, any NaN input gives quieted A if A is NaN, otherwise quieted B.
- R8: In family 10, two NaN inputs give quieted A, and a single NaN input gives the other operand unchanged.
- R9: In family 11, any NaN input gives B unchanged.
- R10: `snan_flag` is high with a valid result exactly when either captured operand is a signaling NaN, in every mode.
- R11: `wr_en` is high with a valid result unless `trap_en` was captured as 1 and a signaling NaN is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for operands, mode and trap enable |
| op_a | input | 64 | Operand A, double-precision bit pattern |
| op_b | input | 64 | Operand B, double-precision bit pattern |
| mode | input | 4 | [3] max, [2] magnitude order, [1:0] NaN family |
| trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Selected minimum or maximum |
| snan_flag | output | 1 | A signaling NaN was among the operands |
| wr_en | output | 1 | Permission to write the result |

## Verification
Random 64-bit patterns almost never form a NaN, a signaling NaN, a signed zero or two operands of equal magnitude and opposite sign. Yet these are exactly the cases where the sixteen modes differ. The random stimulus therefore draws each operand from weighted categories: quiet and signaling NaNs with random payloads, both zeros, both infinities, the negation of the other operand, and free bit patterns. Directed cases pin the family-00 priority chain and the trap gating of the write-enable.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    localparam int FP_W    = 64;
    localparam int FP_EXPW = 11;

    typedef enum logic [1:0] {
        FAM_NUM08    = 2'b00,
        FAM_STRICT19 = 2'b01,
        FAM_NUM19    = 2'b10,
        FAM_CSEL     = 2'b11
    } fam_e;

    typedef struct packed {
        logic is_max;
        logic use_mag;
        fam_e fam;
    } mode_t;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } fmm_state_e;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
    parameter int FW   = 64,
    parameter int EXPW = 11
) (
    input  logic [FW-1:0] x,
    output logic [FW-1:0] mag,
    output logic          is_nan,
    output logic          is_snan,
    output logic          is_zero,
    output logic [FW-1:0] quieted
);
    localparam int MANW = FW - EXPW - 1;
    localparam int QBIT = MANW - 1;
    localparam logic [FW-1:0] INF_PAT = {1'b0, {EXPW{1'b1}}, {MANW{1'b0}}};

    always_comb begin
        mag     = {1'b0, x[FW-2:0]};
        is_nan  = mag > INF_PAT;
        is_snan = is_nan & ~x[QBIT];
        is_zero = (mag == '0);
        quieted = x;
        quieted[QBIT] = 1'b1;
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
    parameter int FW = 64
) (
    input  logic [FW-1:0] a,
    input  logic [FW-1:0] b,
    input  logic [FW-1:0] mag_a,
    input  logic [FW-1:0] mag_b,
    input  logic          zero_a,
    input  logic          zero_b,
    input  logic          use_mag,
    input  logic          zero_eq,
    input  logic          is_max,
    output logic          pick_a
);
    logic [FW-1:0] lhs, rhs, l_ord, r_ord;

    always_comb begin
        lhs = a;
        rhs = b;
        if (use_mag && (mag_a != mag_b)) begin
            lhs = mag_a;
            rhs = mag_b;
        end
        if (zero_eq) begin
            if (zero_a) lhs = '0;
            if (zero_b) rhs = '0;
        end
        if (is_max) begin
            l_ord = rhs;
            r_ord = lhs;
        end else begin
            l_ord = lhs;
            r_ord = rhs;
        end
        if (l_ord[FW-1]) begin
            if (!r_ord[FW-1]) pick_a = 1'b1;
            else              pick_a = (l_ord > r_ord);
        end else if (r_ord[FW-1]) begin
            pick_a = 1'b0;
        end else begin
            pick_a = (l_ord < r_ord);
        end
    end
endmodule

// File: rtl/fmm_nan_sel.sv
module fmm_nan_sel
    import fmm_pkg::*;
#(
    parameter int FW = 64
) (
    input  fam_e          fam,
    input  logic [FW-1:0] a,
    input  logic [FW-1:0] b,
    input  logic [FW-1:0] qa,
    input  logic [FW-1:0] qb,
    input  logic          a_nan,
    input  logic          b_nan,
    input  logic          a_snan,
    input  logic          b_snan,
    output logic [FW-1:0] nres
);
    always_comb begin
        nres = b;
        unique case (fam)
            FAM_NUM08: begin
                if (a_snan)               nres = qa;
                else if (b_snan)          nres = qb;
                else if (a_nan && b_nan)  nres = qa;
                else if (a_nan)           nres = b;
                else                      nres = a;
            end
            FAM_STRICT19: nres = a_nan ? qa : qb;
            FAM_NUM19: begin
                if (a_nan && b_nan)       nres = qa;
                else if (a_nan)           nres = b;
                else                      nres = a;
            end
            FAM_CSEL:                     nres = b;
            default:                      nres = b;
        endcase
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter int FW   = FP_W,
    parameter int EXPW = FP_EXPW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [FW-1:0] op_a,
    input  logic [FW-1:0] op_b,
    input  logic [3:0]    mode,
    input  logic          trap_en,
    output logic          out_valid,
    output logic [FW-1:0] result,
    output logic          snan_flag,
    output logic          wr_en
);
    localparam int NOPS = 2;

    fmm_state_e    st_q, st_d;
    logic [FW-1:0] a_q, b_q;
    mode_t         mode_q;
    logic          trap_q;

    logic [FW-1:0] opnd    [NOPS];
    logic [FW-1:0] mag     [NOPS];
    logic [FW-1:0] quiet   [NOPS];
    logic          nan_f   [NOPS];
    logic          snan_f  [NOPS];
    logic          zero_f  [NOPS];

    logic          pick_a;
    logic [FW-1:0] nan_res;
    logic          any_nan, any_snan;
    logic [FW-1:0] res_c;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY:  if (in_valid)  st_d = ST_LOADED;
            ST_LOADED: if (!in_valid) st_d = ST_EMPTY;
            default:                  st_d = ST_EMPTY;
        endcase
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= '0;
            trap_q <= 1'b0;
        end else if (in_valid) begin
            a_q    <= op_a;
            b_q    <= op_b;
            mode_q <= mode_t'(mode);
            trap_q <= trap_en;
        end
    end

    assign opnd[0] = a_q;
    assign opnd[1] = b_q;

    generate
        for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
            fmm_classify #(.FW(FW), .EXPW(EXPW)) u_cls (
                .x       (opnd[gi]),
                .mag     (mag[gi]),
                .is_nan  (nan_f[gi]),
                .is_snan (snan_f[gi]),
                .is_zero (zero_f[gi]),
                .quieted (quiet[gi])
            );
        end
    endgenerate

    fmm_order #(.FW(FW)) u_order (
        .a       (a_q),
        .b       (b_q),
        .mag_a   (mag[0]),
        .mag_b   (mag[1]),
        .zero_a  (zero_f[0]),
        .zero_b  (zero_f[1]),
        .use_mag (mode_q.use_mag),
        .zero_eq (mode_q.fam == FAM_CSEL),
        .is_max  (mode_q.is_max),
        .pick_a  (pick_a)
    );

    fmm_nan_sel #(.FW(FW)) u_nan (
        .fam    (mode_q.fam),
        .a      (a_q),
        .b      (b_q),
        .qa     (quiet[0]),
        .qb     (quiet[1]),
        .a_nan  (nan_f[0]),
        .b_nan  (nan_f[1]),
        .a_snan (snan_f[0]),
        .b_snan (snan_f[1]),
        .nres   (nan_res)
    );

    always_comb begin
        any_nan  = nan_f[0] | nan_f[1];
        any_snan = snan_f[0] | snan_f[1];
        res_c    = any_nan ? nan_res : (pick_a ? a_q : b_q);
    end

    // outputs
    always_comb begin
        out_valid = (st_q == ST_LOADED);
        result    = out_valid ? res_c : '0;
        snan_flag = out_valid & any_snan;
        wr_en     = out_valid & ~(trap_q & any_snan);
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_pick_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result == a_q || result == b_q ||
                       result == quiet[0] || result == quiet[1]));
    assert_csel_nan_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q.fam == FAM_CSEL && (nan_f[0] || nan_f[1])) |-> result == b_q);
    assert_snan_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snan_flag |-> out_valid);
    assert_trap_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && trap_q && snan_flag) |-> !wr_en);
    assert_write_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !snan_flag) |-> wr_en);
endmodule

// File: tb/fmm_unit_tb.sv
`timescale 1ns/1ps
module fmm_unit_tb;
    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] NTWO = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] NQN  = 64'hFFF8_0000_0000_0000;
    localparam logic [63:0] SN   = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] SNQ  = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SN2  = 64'h7FF4_0000_0000_0000;
    localparam logic [63:0] SN2Q = 64'h7FFC_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [3:0]  mode = '0;
    logic        trap_en = 1'b0;
    logic        out_valid, snan_flag, wr_en;
    logic [63:0] result;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fmm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .trap_en(trap_en), .out_valid(out_valid), .result(result),
        .snan_flag(snan_flag), .wr_en(wr_en)
    );

    function automatic bit f_nan(logic [63:0] x);
        return {1'b0, x[62:0]} > PINF;
    endfunction
    function automatic bit f_snan(logic [63:0] x);
        return f_nan(x) && !x[51];
    endfunction
    function automatic logic [63:0] f_q(logic [63:0] x);
        return x | 64'h0008_0000_0000_0000;
    endfunction
    // total order key: -0 below +0
    function automatic logic [63:0] f_key(logic [63:0] x);
        return x[63] ? ~x : (x | 64'h8000_0000_0000_0000);
    endfunction

    function automatic logic [63:0] f_ref(logic [63:0] a, logic [63:0] b, logic [3:0] m);
        bit an = f_nan(a), bn = f_nan(b);
        logic [63:0] ma = {1'b0, a[62:0]}, mb = {1'b0, b[62:0]};
        if (an || bn) begin
            case (m[1:0])
                2'b00: begin
                    if (f_snan(a)) return f_q(a);
                    if (f_snan(b)) return f_q(b);
                    if (an && bn)  return f_q(a);
                    return an ? b : a;
                end
                2'b01: return an ? f_q(a) : f_q(b);
                2'b10: begin
                    if (an && bn) return f_q(a);
                    return an ? b : a;
                end
                default: return b;
            endcase
        end
        if (m[2] && ma != mb) begin
            bit asmall = ma < mb;
            return (m[3] ? !asmall : asmall) ? a : b;
        end
        if (m[1:0] == 2'b11 && ma == 0 && mb == 0) return b;
        if (m[3]) return (f_key(a) > f_key(b)) ? a : b;
        return (f_key(a) < f_key(b)) ? a : b;
    endfunction

    function automatic string f_tag(logic [63:0] a, logic [63:0] b, logic [3:0] m);
        if (f_nan(a) || f_nan(b)) begin
            case (m[1:0])
                2'b00: return "R6";
                2'b01: return "R7";
                2'b10: return "R8";
                default: return "R9";
            endcase
        end
        if (m[2]) return "R5";
        if (m[1:0] == 2'b11) return "R4";
        return "R3";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one strobe, then check the result one cycle later
    task automatic do_op(logic [63:0] a, logic [63:0] b, logic [3:0] m, logic t,
                         logic [63:0] er, string tag);
        bit es;
        @(negedge clk);
        op_a = a; op_b = b; mode = m; trap_en = t; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        es = f_snan(a) || f_snan(b);
        chk("R2", {63'd0, out_valid}, 64'd1);
        chk(tag, result, er);
        chk("R10", {63'd0, snan_flag}, {63'd0, es});
        chk("R11", {63'd0, wr_en}, {63'd0, !(t && es)});
    endtask

    function automatic logic [63:0] rand_op(logic [63:0] other);
        logic [63:0] r = {$urandom, $urandom};
        case ($urandom % 9)
            0: return {r[63], 11'h7FF, 1'b1, r[50:0]};
            1: return {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
            2: return r[0] ? NZ : PZ;
            3: return r[0] ? NINF : PINF;
            4: return {~other[63], other[62:0]};
            5: return other;
            default: return r;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {out_valid, wr_en, snan_flag}, 3'b000);
        chk("R1", result, 64'd0);

        // R3 ordinary ordering
        do_op(ONE, TWO, 4'b0000, 1'b0, ONE, "R3");
        do_op(ONE, TWO, 4'b1000, 1'b0, TWO, "R3");
        do_op(NONE, NTWO, 4'b0000, 1'b0, NTWO, "R3");
        do_op(NZ, PZ, 4'b1010, 1'b0, PZ, "R3");
        do_op(PZ, NZ, 4'b0001, 1'b0, NZ, "R3");
        do_op(PINF, ONE, 4'b0000, 1'b0, ONE, "R3");
        do_op(PINF, ONE, 4'b1000, 1'b0, PINF, "R3");
        // R4 compare-select zeros
        do_op(NZ, PZ, 4'b0011, 1'b0, PZ, "R4");
        do_op(PZ, NZ, 4'b1011, 1'b0, NZ, "R4");
        // R5 magnitude
        do_op(NTWO, ONE, 4'b0100, 1'b0, ONE, "R5");
        do_op(NTWO, ONE, 4'b1100, 1'b0, NTWO, "R5");
        do_op(NONE, ONE, 4'b0110, 1'b0, NONE, "R5");
        do_op(PINF, NINF, 4'b1111, 1'b0, PINF, "R5");
        // R6 family 00 priority chain
        do_op(QN, ONE, 4'b0000, 1'b0, ONE, "R6");
        do_op(ONE, SN, 4'b0000, 1'b0, SNQ, "R6");
        do_op(QN, SN2, 4'b1000, 1'b0, SN2Q, "R6");
        do_op(QN, NQN, 4'b0000, 1'b0, QN, "R6");
        do_op(SN, SN2, 4'b0100, 1'b0, SNQ, "R6");
        // R7
        do_op(ONE, QN, 4'b0001, 1'b0, QN, "R7");
        do_op(NQN, ONE, 4'b1001, 1'b0, NQN, "R7");
        do_op(ONE, SN, 4'b0001, 1'b0, SNQ, "R7");
        // R8
        do_op(QN, ONE, 4'b0010, 1'b0, ONE, "R8");
        do_op(ONE, NQN, 4'b1010, 1'b0, ONE, "R8");
        do_op(SN, QN, 4'b0010, 1'b0, SNQ, "R8");
        // R9
        do_op(QN, ONE, 4'b0011, 1'b0, ONE, "R9");
        do_op(ONE, SN, 4'b0011, 1'b0, SN, "R9");
        // R10 / R11 trap gating
        do_op(SN, ONE, 4'b0000, 1'b1, SNQ, "R11");
        do_op(ONE, TWO, 4'b0000, 1'b1, ONE, "R11");
        do_op(ONE, SN2, 4'b1011, 1'b1, SN2, "R10");

        // R2 idle after a strobe, then back-to-back strobes
        @(negedge clk);
        chk("R2", {63'd0, out_valid}, 64'd0);
        op_a = ONE; op_b = TWO; mode = 4'b0000; in_valid = 1'b1; trap_en = 1'b0;
        @(negedge clk);
        chk("R2", result, ONE);
        op_a = ONE; op_b = TWO; mode = 4'b1000;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", {63'd0, out_valid}, 64'd1);
        chk("R2", result, TWO);
        @(negedge clk);
        chk("R2", {63'd0, out_valid}, 64'd0);

        // random mixed stimulus over all sixteen modes
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] ra, rb;
            logic [3:0] rm;
            logic rt;
            ra = rand_op(ONE);
            rb = rand_op(ra);
            rm = 4'($urandom);
            rt = 1'($urandom);
            do_op(ra, rb, rm, rt, f_ref(ra, rb, rm), f_tag(ra, rb, rm));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule